// File: doc/BRIEF.md
# Three-Path Host Stream Arbiter

This block takes a stream of host command words and sorts each word by a 2-bit path tag into one of three streams. Geometry-bound 3D words are queued and sent out on a dedicated port toward an external geometry processing chain. 2D words and urgent bypass words each wait in their own queue. The results that come back from the geometry chain count as 3D traffic. The block merges those results, the 2D words and the bypass words onto a single shared downstream link.

The bypass path always wins the shared link. It exists so that urgent traffic can get past a stalled pipeline, for example a texture cache fill that a primitive currently being drawn depends on. 2D words are not merely given lower priority. They are fenced: a 2D word may leave only when no 3D word accepted at the host port before it is still unforwarded. A counter tracks 3D words that have been accepted but not yet forwarded, and the fence opens only when that counter is zero. Every port uses a valid/ready handshake.

The output is one holding register, controlled by a four-state machine:
- **EMPTY**: nothing is held.
- **HOLD_UB**, **HOLD_3D**, **HOLD_2D**: a word from the named path is held.

State transitions:
- **load**: taken from EMPTY, or from any HOLD state in a cycle where the held word is accepted. The next state is the path of the winning word.
- **drain**: a HOLD state whose word is accepted, with no candidate waiting, returns to EMPTY.
- **stall**: a HOLD state with ready low stays where it is.

Top module: `host_stream_arbiter`

## Requirements
- R1: Tag 00 routes a word to the geometry port, tag 01 to the 2D queue and tag 10 to the bypass queue. The output source code is 00 for geometry results, 01 for 2D and 10 for bypass. 3D words appear on the geometry port unchanged and in host order. The geometry port holds its word steady while its ready is low.
- R2: A word tagged 11 is accepted at once. It is dropped, and it reaches neither the geometry port nor the output.
- R3: Within each path, words leave in arrival order with their data unchanged. For 3D, arrival order is the order in which results return.
- R4: Whenever the output register is free to load and a bypass word is queued, the next word loaded is a bypass word, ahead of waiting 3D results and 2D words.
- R5: A 2D word is output only after every 3D word accepted at the host before it has been forwarded. While the fence is up, waiting 3D results go first.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_src stay unchanged.
- R7: After reset, out_valid and geo_valid are low, and host_ready is high for every tag.
- R8: When the count of accepted but unforwarded 3D words reaches 2^CNT_W-1, host_ready drops for tag 00. Other tags are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host word valid |
| host_ready | output | 1 | Host word accepted |
| host_tag | input | 2 | Path tag (00 3D, 01 2D, 10 bypass, 11 dropped) |
| host_data | input | DW | Host word payload |
| geo_valid | output | 1 | Word offered to geometry chain |
| geo_ready | input | 1 | Geometry chain takes the word |
| geo_data | output | DW | Word to geometry chain |
| ret_valid | input | 1 | Geometry result valid |
| ret_ready | output | 1 | Result taken by the arbiter |
| ret_data | input | DW | Geometry result payload |
| out_valid | output | 1 | Shared link word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DW | Shared link payload |
| out_src | output | 2 | Source path of the held word |

## Verification
The block is exercised with several kinds of input, and each one separates a different behaviour:
- **Random mixed traffic.** Tags are mixed at random while the geometry and downstream ready signals are random. Because each source has its own queue, this catches reordering or corruption within one path and any 2D word that overtakes earlier 3D work.
- **Blocked output.** With the output held blocked, two 3D results and two bypass words pile up. This shows whether bypass jumps ahead of an already-returned 3D result.
- **Stalled geometry chain.** A stalled chain with a 2D word queued behind a 3D word tells a real fence apart from plain lower priority.
- **Reserved tag.** A tagged-11 word shows whether it is dropped.
- **Filled counter.** Accepting 63 3D words while returns are withheld shows whether the counter limit throttles only the 3D tag.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    typedef enum logic [1:0] {
        TAG_3D  = 2'b00,
        TAG_2D  = 2'b01,
        TAG_UB  = 2'b10,
        TAG_RSV = 2'b11
    } path_tag_e;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_HOLD_UB,
        ST_HOLD_3D,
        ST_HOLD_2D
    } out_state_e;

    localparam int NUM_PATHS = 3;
    localparam int PI_3D     = 0;
    localparam int PI_2D     = 1;
    localparam int PI_UB     = 2;

endpackage

// File: rtl/hsa_fifo.sv
module hsa_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign valid   = (fill != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rd_idx];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] idx);
        return (idx == AW'(DEPTH - 1)) ? '0 : idx + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_idx] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_idx <= step(wr_idx);
            if (do_pop)  rd_idx <= step(rd_idx);
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/hsa_ingress.sv
module hsa_ingress
    import hsa_pkg::*;
(
    input  logic                 host_valid,
    input  logic [1:0]           host_tag,
    input  logic [NUM_PATHS-1:0] path_full,
    input  logic                 fence_at_max,
    output logic                 host_ready,
    output logic [NUM_PATHS-1:0] path_push
);
    path_tag_e tag;
    assign tag = path_tag_e'(host_tag);

    always_comb begin
        unique case (tag)
            TAG_3D:  host_ready = !path_full[PI_3D] && !fence_at_max;
            TAG_2D:  host_ready = !path_full[PI_2D];
            TAG_UB:  host_ready = !path_full[PI_UB];
            TAG_RSV: host_ready = 1'b1;
        endcase
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_push
        assign path_push[p] = host_valid && host_ready && (host_tag == 2'(p));
    end

endmodule

// File: rtl/hsa_fence_ctr.sv
module hsa_fence_ctr #(
    parameter int CW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic zero,
    output logic at_max
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic [CW-1:0] cnt;

    assign zero   = (cnt == '0);
    assign at_max = (cnt == MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/hsa_out_sel.sv
module hsa_out_sel
    import hsa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ub_valid,
    input  logic [W-1:0] ub_data,
    input  logic         ret_valid,
    input  logic [W-1:0] ret_data,
    input  logic         td_valid,
    input  logic [W-1:0] td_data,
    input  logic         fence_clear,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic [1:0]   out_src,
    output logic         ub_pop,
    output logic         td_pop,
    output logic         ret_ready,
    output logic         fwd_3d
);
    out_state_e   state_q, state_d;
    logic [W-1:0] data_q, data_d;
    logic         slot_free;

    always_comb begin
        slot_free = (state_q == ST_EMPTY) || out_ready;
        state_d   = state_q;
        data_d    = data_q;
        ub_pop    = 1'b0;
        ret_ready = 1'b0;
        td_pop    = 1'b0;
        if (slot_free) begin
            if (ub_valid) begin
                ub_pop    = 1'b1;
                state_d   = ST_HOLD_UB;
                data_d    = ub_data;
            end else if (ret_valid) begin
                ret_ready = 1'b1;
                state_d   = ST_HOLD_3D;
                data_d    = ret_data;
            end else if (td_valid && fence_clear) begin
                td_pop    = 1'b1;
                state_d   = ST_HOLD_2D;
                data_d    = td_data;
            end else begin
                state_d   = ST_EMPTY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        out_data = data_q;
        unique case (state_q)
            ST_EMPTY:   begin out_valid = 1'b0; out_src = TAG_3D; end
            ST_HOLD_UB: begin out_valid = 1'b1; out_src = TAG_UB; end
            ST_HOLD_3D: begin out_valid = 1'b1; out_src = TAG_3D; end
            ST_HOLD_2D: begin out_valid = 1'b1; out_src = TAG_2D; end
        endcase
        fwd_3d = (state_q == ST_HOLD_3D) && out_ready;
    end

endmodule

// File: rtl/host_stream_arbiter.sv
module host_stream_arbiter
    import hsa_pkg::*;
#(
    parameter int DW       = 32,
    parameter int DEPTH_3D = 4,
    parameter int DEPTH_2D = 4,
    parameter int DEPTH_UB = 4,
    parameter int CNT_W    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_valid,
    output logic          host_ready,
    input  logic [1:0]    host_tag,
    input  logic [DW-1:0] host_data,
    output logic          geo_valid,
    input  logic          geo_ready,
    output logic [DW-1:0] geo_data,
    input  logic          ret_valid,
    output logic          ret_ready,
    input  logic [DW-1:0] ret_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [1:0]    out_src
);
    logic [NUM_PATHS-1:0] f_push, f_pop, f_vld, f_full;
    logic [DW-1:0]        f_dout [NUM_PATHS];
    logic                 cnt_zero, cnt_max, fwd_3d, ub_pop, td_pop;
    logic                 ub_pending, fence_busy;

    hsa_ingress u_ingress (
        .host_valid   (host_valid),
        .host_tag     (host_tag),
        .path_full    (f_full),
        .fence_at_max (cnt_max),
        .host_ready   (host_ready),
        .path_push    (f_push)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        localparam int FD = (p == PI_3D) ? DEPTH_3D :
                            (p == PI_2D) ? DEPTH_2D : DEPTH_UB;
        hsa_fifo #(.W(DW), .DEPTH(FD)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (f_push[p]),
            .din   (host_data),
            .full  (f_full[p]),
            .pop   (f_pop[p]),
            .valid (f_vld[p]),
            .dout  (f_dout[p])
        );
    end

    assign geo_valid     = f_vld[PI_3D];
    assign geo_data      = f_dout[PI_3D];
    assign f_pop[PI_3D]  = geo_valid && geo_ready;
    assign f_pop[PI_2D]  = td_pop;
    assign f_pop[PI_UB]  = ub_pop;

    hsa_fence_ctr #(.CW(CNT_W)) u_fence (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (f_push[PI_3D]),
        .dec    (fwd_3d),
        .zero   (cnt_zero),
        .at_max (cnt_max)
    );

    hsa_out_sel #(.W(DW)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ub_valid    (f_vld[PI_UB]),
        .ub_data     (f_dout[PI_UB]),
        .ret_valid   (ret_valid),
        .ret_data    (ret_data),
        .td_valid    (f_vld[PI_2D]),
        .td_data     (f_dout[PI_2D]),
        .fence_clear (cnt_zero),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_src     (out_src),
        .ub_pop      (ub_pop),
        .td_pop      (td_pop),
        .ret_ready   (ret_ready),
        .fwd_3d      (fwd_3d)
    );

    assign ub_pending = f_vld[PI_UB];
    assign fence_busy = !cnt_zero;

endmodule

// File: rtl/host_stream_arbiter_chk.sv
module host_stream_arbiter_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_valid,
    input logic          host_ready,
    input logic [1:0]    host_tag,
    input logic          geo_valid,
    input logic          geo_ready,
    input logic [DW-1:0] geo_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic [1:0]    out_src,
    input logic          ub_pending,
    input logic          fence_busy
);
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_src));

    p_geo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid && !geo_ready |=> geo_valid && $stable(geo_data));

    p_src_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_src != 2'b11);

    p_bypass_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ub_pending && (!out_valid || out_ready) |=> out_valid && out_src == 2'b10);

    p_fence_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fence_busy && (!out_valid || out_ready) |=> !(out_valid && out_src == 2'b01));

    p_drop_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_tag == 2'b11 |-> host_ready);

endmodule

bind host_stream_arbiter host_stream_arbiter_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_tag   (host_tag),
    .geo_valid  (geo_valid),
    .geo_ready  (geo_ready),
    .geo_data   (geo_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_src    (out_src),
    .ub_pending (ub_pending),
    .fence_busy (fence_busy)
);

// File: tb/host_stream_arbiter_tb.sv
module host_stream_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GEO_KEY = 32'h5A5A_0F0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_ready;
    logic [1:0]  host_tag = 2'b00;
    logic [31:0] host_data = '0;
    logic        geo_valid, geo_ready = 1'b0;
    logic [31:0] geo_data;
    logic        ret_valid = 1'b0, ret_ready;
    logic [31:0] ret_data = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [31:0] out_data;
    logic [1:0]  out_src;

    always #(CLK_PERIOD / 2) clk = ~clk;

    host_stream_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_tag(host_tag), .host_data(host_data),
        .geo_valid(geo_valid), .geo_ready(geo_ready), .geo_data(geo_data),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_data(ret_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_src(out_src)
    );

    int n_chk = 0, n_bad = 0;
    int out_mode = 0, geo_mode = 0, ret_en = 1;
    int n3_acc = 0, n3_out = 0, n_geo = 0;
    logic [31:0] q_geo_exp[$], q_ret[$], q_e3[$], q_e2[$], q_eu[$];
    int          q_e2_need[$];
    logic [33:0] log_q[$];
    logic        ret_drop = 1'b0, prev_stall = 1'b0;
    logic [31:0] prev_data;
    logic [1:0]  prev_src;

    function automatic logic [31:0] geo_xform(input logic [31:0] d);
        return d ^ GEO_KEY;
    endfunction

    task automatic check(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit pick(input int mode);
        return (mode == 1) || (mode == 2 && ($urandom % 3) != 0);
    endfunction

    // Drive ready/return at falling edge, sample handshakes just after.
    always @(negedge clk) begin
        if (rst_n) begin
            out_ready = pick(out_mode);
            geo_ready = pick(geo_mode);
            if (ret_drop) begin ret_valid = 1'b0; ret_drop = 1'b0; end
            if (!ret_valid && q_ret.size() > 0 && ret_en != 0 && ($urandom % 4) != 0) begin
                ret_valid = 1'b1;
                ret_data  = q_ret[0];
            end
            #1;
            if (prev_stall)  // R6
                check(out_valid && out_data == prev_data && out_src == prev_src, "R6 hold",
                      {out_src, out_data}, {prev_src, prev_data});
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_src   = out_src;
            if (geo_valid && geo_ready) begin  // R1
                n_geo++;
                if (q_geo_exp.size() == 0) check(0, "R1 unexpected geo word", {2'b00, geo_data}, '0);
                else begin
                    check(geo_data == q_geo_exp[0], "R1 geo data", {2'b00, geo_data}, {2'b00, q_geo_exp[0]});
                    void'(q_geo_exp.pop_front());
                end
                q_ret.push_back(geo_xform(geo_data));
                q_e3.push_back(geo_xform(geo_data));
            end
            if (ret_valid && ret_ready) begin
                void'(q_ret.pop_front());
                ret_drop = 1'b1;
            end
            if (out_valid && out_ready) begin
                log_q.push_back({out_src, out_data});
                unique case (out_src)
                    2'b00: begin  // R3
                        if (q_e3.size() == 0) check(0, "R3 unexpected 3D", {out_src, out_data}, '0);
                        else begin
                            check(out_data == q_e3[0], "R3 3D order", {out_src, out_data}, {2'b00, q_e3[0]});
                            void'(q_e3.pop_front());
                        end
                        n3_out++;
                    end
                    2'b01: begin  // R3, R5
                        if (q_e2.size() == 0) check(0, "R2 R3 unexpected 2D", {out_src, out_data}, '0);
                        else begin
                            check(out_data == q_e2[0], "R3 2D order", {out_src, out_data}, {2'b01, q_e2[0]});
                            check(n3_out >= q_e2_need[0], "R5 fence", 34'(n3_out), 34'(q_e2_need[0]));
                            void'(q_e2.pop_front());
                            void'(q_e2_need.pop_front());
                        end
                    end
                    2'b10: begin  // R3
                        if (q_eu.size() == 0) check(0, "R2 R3 unexpected bypass", {out_src, out_data}, '0);
                        else begin
                            check(out_data == q_eu[0], "R3 bypass order", {out_src, out_data}, {2'b10, q_eu[0]});
                            void'(q_eu.pop_front());
                        end
                    end
                    default: check(0, "R1 source code", {out_src, out_data}, '0);
                endcase
            end
        end
    end

    task automatic send(input logic [1:0] t, input logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_tag = t; host_data = d;
        #2;
        while (!host_ready) begin @(negedge clk); #2; end
        unique case (t)
            2'b00: begin q_geo_exp.push_back(d); n3_acc++; end
            2'b01: begin q_e2.push_back(d); q_e2_need.push_back(n3_acc); end
            2'b10: q_eu.push_back(d);
            default: ;
        endcase
        @(posedge clk); #1;
        host_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R7 reset state
        check(!out_valid, "R7 out_valid", 34'(out_valid), 34'd0);
        check(!geo_valid, "R7 geo_valid", 34'(geo_valid), 34'd0);
        for (int t = 0; t < 4; t++) begin
            host_tag = 2'(t); #1;
            check(host_ready, "R7 host_ready", 34'(host_ready), 34'd1);
        end
        host_tag = 2'b00;

        // R4: bypass overtakes a waiting 3D result
        out_mode = 0; geo_mode = 1; ret_en = 1;
        log_q.delete();
        send(2'b00, 32'hA000_0001);
        send(2'b00, 32'hA000_0002);
        idle(12);
        send(2'b10, 32'hB000_0001);
        send(2'b10, 32'hB000_0002);
        idle(4);
        out_mode = 1;
        idle(10);
        check(log_q.size() == 4, "R4 count", 34'(log_q.size()), 34'd4);
        if (log_q.size() == 4) begin
            check(log_q[0] == {2'b00, geo_xform(32'hA000_0001)}, "R4 first", log_q[0], {2'b00, geo_xform(32'hA000_0001)});
            check(log_q[1] == {2'b10, 32'hB000_0001}, "R4 bypass1", log_q[1], {2'b10, 32'hB000_0001});
            check(log_q[2] == {2'b10, 32'hB000_0002}, "R4 bypass2", log_q[2], {2'b10, 32'hB000_0002});
            check(log_q[3] == {2'b00, geo_xform(32'hA000_0002)}, "R4 last", log_q[3], {2'b00, geo_xform(32'hA000_0002)});
        end

        // R5: 2D fenced behind a stalled 3D word
        geo_mode = 0; log_q.delete();
        send(2'b00, 32'hC000_0001);
        send(2'b01, 32'hD000_0001);
        idle(8);
        check(log_q.size() == 0, "R5 2D held", 34'(log_q.size()), 34'd0);
        geo_mode = 1;
        idle(12);
        check(log_q.size() == 2, "R5 count", 34'(log_q.size()), 34'd2);
        if (log_q.size() == 2) begin
            check(log_q[0] == {2'b00, geo_xform(32'hC000_0001)}, "R5 3D first", log_q[0], {2'b00, geo_xform(32'hC000_0001)});
            check(log_q[1] == {2'b01, 32'hD000_0001}, "R5 2D after", log_q[1], {2'b01, 32'hD000_0001});
        end

        // R2: reserved tag dropped
        log_q.delete();
        begin
            int g0;
            g0 = n_geo;
            send(2'b11, 32'hE000_0001);
            idle(8);
            check(log_q.size() == 0, "R2 no output", 34'(log_q.size()), 34'd0);
            check(n_geo == g0, "R2 no geo word", 34'(n_geo), 34'(g0));
        end

        // R8: counter limit throttles only 3D
        ret_en = 0;
        for (int i = 0; i < 63; i++) send(2'b00, 32'hF000_0000 + 32'(i));
        idle(3);
        @(negedge clk);
        host_valid = 1'b1; host_tag = 2'b00; host_data = 32'hF0FF_FFFF; #2;
        check(!host_ready, "R8 3D refused", 34'(host_ready), 34'd0);
        host_tag = 2'b10; #1;
        check(host_ready, "R8 bypass open", 34'(host_ready), 34'd1);
        host_valid = 1'b0; host_tag = 2'b00;
        ret_en = 1;
        idle(200);

        // Random mixed traffic (R1, R3, R5, R6)
        out_mode = 2; geo_mode = 2;
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [1:0] t;
            r = int'($urandom % 8);
            t = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
            send(t, $urandom);
            if (($urandom % 5) == 0) idle(int'($urandom % 4));
        end
        out_mode = 1; geo_mode = 1;
        for (int i = 0; i < 3000; i++) begin
            if (q_e3.size() + q_e2.size() + q_eu.size() + q_geo_exp.size() + q_ret.size() == 0) break;
            @(negedge clk);
        end
        idle(5);
        check(q_geo_exp.size() == 0, "R1 geo drained", 34'(q_geo_exp.size()), 34'd0);
        check(q_e3.size() == 0, "R3 3D drained", 34'(q_e3.size()), 34'd0);
        check(q_e2.size() == 0, "R5 2D drained", 34'(q_e2.size()), 34'd0);
        check(q_eu.size() == 0, "R4 bypass drained", 34'(q_eu.size()), 34'd0);
        summary();
        $finish;
    end

endmodule